// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit load/store processor core for a small subset of a classic RISC instruction set. It is cut into five stages: fetch, decode, execute, memory access and writeback. A clocked register stands between each pair of neighbouring stages, so one instruction enters the pipe on every clock. The core executes word loads, word stores and the register-to-register operations add, subtract, AND, OR and shift-left-logical. The all-zero word is a shift of register 0 into register 0, which is how the pipe idles.

The instruction store is a small read-only array. It holds a fixed hazard-free self-test program that is built from field-encoding functions at elaboration. The data store is a small synchronous array. It captures its address and write data in its own input registers on the same rising edge that loads the execute-to-memory register. The core has no hazard detection, no forwarding and no flushing. Software must space a producer and its consumer at least three instructions apart. The only outputs are debug taps: program counter, fetched word, execute-stage ALU value, writeback data, destination and enable, and the store strobe.

Top module: `pipe5_core`

## Requirements
- R1: While the synchronous reset is high, the PC is 0, the fetch register holds the all-zero no-op word, and the writeback enable and store strobe are both low.
- R2: After reset, the PC advances by 4 on every rising edge. After each edge the fetch register holds the instruction word that was at the previous PC.
- R3: Suppose an instruction enters the fetch register at edge k. Its ALU value is visible after edge k+1. Its writeback data, destination and enable are visible after edge k+3. It is written into the register file at edge k+4.
- R4: Opcode 0 (bits 31:26) selects the register-register path. The ALU function is taken from bits 5:0 of the sign-extended immediate: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x00 shift rt left by bits 10:6.
- R5: Opcode 0x23 loads. The address is rs (bits 25:21) plus the sign-extended 16-bit immediate. Its low bits form a word index, and the loaded word is written to rt.
- R6: Opcode 0x2B stores rt to the word addressed as in R5. The store is written on the same edge that captures the address, and it makes no register writeback. A later load of that word returns the stored value.
- R7: After reset, data word 21 is 0xAAAA5555, data word 25 is 0x5555AAAA, and every other data word is zero.
- R8: Register 0 reads as zero. A write to it is presented at writeback but has no effect, and a later read of register 0 still returns zero.
- R9: The destination register is rd (bits 15:11) for register-register operations and rt (bits 20:16) for loads.
- R10: A register read in the same cycle as a writeback to that register returns the new value.
- R11: A negative immediate is sign-extended before the address is formed, so an offset of -1 from register 22 addresses word 21.
- R12: Reset loads register i of the register file with the value i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Current program counter |
| dbg_instr | output | 32 | Instruction word in the fetch/decode register |
| dbg_alu | output | 32 | ALU result of the instruction in execute |
| dbg_wb_data | output | 32 | Data chosen by the writeback mux |
| dbg_wb_reg | output | 5 | Destination register at writeback |
| dbg_wb_en | output | 1 | Register write enable at writeback |
| dbg_mem_we | output | 1 | Store strobe of the instruction in execute |

## Verification
Each stage register is visible at the ports a fixed number of cycles after fetch, so a fault in one shows up quickly. A bad decode or ALU select shows one edge after fetch on the ALU tap. A bad destination or mux select shows three edges after fetch on the writeback taps. A corrupted register-file or data-memory word stays hidden until a later instruction reads it. The built-in program therefore follows each store with a load and each write with a read, including the same-cycle bypass and register 0. Each of those faults then reaches the writeback port within about seven cycles of the write.

// File: rtl/pipe5_core.sv
module pipe5_core #(
  parameter int          XLEN       = 32,
  parameter int          DMEM_DEPTH = 64,
  parameter int          IMEM_DEPTH = 32,
  parameter int          SEED_A_IDX = 21,
  parameter int          SEED_B_IDX = 25,
  parameter logic [31:0] SEED_A     = 32'hAAAA5555,
  parameter logic [31:0] SEED_B     = 32'h5555AAAA
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] dbg_pc,
  output logic [31:0]     dbg_instr,
  output logic [XLEN-1:0] dbg_alu,
  output logic [XLEN-1:0] dbg_wb_data,
  output logic [4:0]      dbg_wb_reg,
  output logic            dbg_wb_en,
  output logic            dbg_mem_we
);
  localparam int DAW  = $clog2(DMEM_DEPTH);
  localparam int IAW  = $clog2(IMEM_DEPTH);
  localparam int NREG = 32;

  localparam logic [5:0] OP_RR = 6'h00, OP_LD = 6'h23, OP_ST = 6'h2B;
  localparam logic [5:0] FN_SLL = 6'h00, FN_ADD = 6'h20, FN_SUB = 6'h22,
                         FN_AND = 6'h24, FN_OR = 6'h25;

  function automatic logic [31:0] rr(input logic [4:0] s, t, d, input logic [5:0] f);
    return {OP_RR, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] ri(input logic [5:0] o, input logic [4:0] s, t,
                                     input logic [15:0] im);
    return {o, s, t, im};
  endfunction

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc_q;
  logic [31:0]     rom_word, fetch_word, ifid_q;
  int              fidx;
  logic            fetch_ok;

  assign fidx     = int'(pc_q[IAW+1:2]);
  assign fetch_ok = (pc_q[1:0] == 2'b00) && (pc_q[XLEN-1:IAW+2] == '0);

  always_comb begin
    case (fidx)
      0:  rom_word = ri(OP_LD, 5'd1, 5'd10, 16'd20);
      1:  rom_word = rr(5'd2, 5'd3, 5'd11, FN_SUB);
      2:  rom_word = rr(5'd4, 5'd5, 5'd12, FN_AND);
      3:  rom_word = rr(5'd6, 5'd7, 5'd13, FN_OR);
      4:  rom_word = rr(5'd8, 5'd9, 5'd14, FN_ADD);
      5:  rom_word = ri(OP_LD, 5'd1, 5'd15, 16'd24);
      6:  rom_word = rr(5'd8, 5'd9, 5'd0, FN_ADD);
      7:  rom_word = rr(5'd14, 5'd11, 5'd20, FN_ADD);
      8:  rom_word = ri(OP_ST, 5'd2, 5'd10, 16'd3);
      9:  rom_word = rr(5'd0, 5'd0, 5'd17, FN_ADD);
      10: rom_word = ri(OP_LD, 5'd22, 5'd21, 16'hFFFF);
      11: rom_word = ri(OP_LD, 5'd0, 5'd16, 16'd5);
      12: rom_word = rr(5'd15, 5'd10, 5'd18, FN_OR);
      13: rom_word = rr(5'd14, 5'd13, 5'd19, FN_SUB);
      default: rom_word = 32'd0;
    endcase
  end
  assign fetch_word = fetch_ok ? rom_word : 32'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      ifid_q <= 32'd0;
    end else begin
      pc_q   <= pc_q + XLEN'(4);
      ifid_q <= fetch_word;
    end
  end

  // ---------------- decode ----------------
  logic [5:0]      d_op;
  logic [4:0]      d_rs, d_rt, d_rd;
  logic [XLEN-1:0] d_imm, d_a, d_b;
  logic            d_rr, d_ld, d_st;
  logic [XLEN-1:0] regs [NREG];

  logic [XLEN-1:0] wb_data;
  logic [4:0]      mw_dst;
  logic            mw_we;

  assign d_op  = ifid_q[31:26];
  assign d_rs  = ifid_q[25:21];
  assign d_rt  = ifid_q[20:16];
  assign d_rd  = ifid_q[15:11];
  assign d_imm = {{(XLEN-16){ifid_q[15]}}, ifid_q[15:0]};
  assign d_rr  = (d_op == OP_RR);
  assign d_ld  = (d_op == OP_LD);
  assign d_st  = (d_op == OP_ST);

  function automatic logic [XLEN-1:0] rf_read(input logic [4:0] r,
                                              input logic [XLEN-1:0] stored,
                                              input logic we, input logic [4:0] wr,
                                              input logic [XLEN-1:0] wd);
    if (r == 5'd0)             return '0;
    else if (we && (wr == r))  return wd;
    else                       return stored;
  endfunction

  assign d_a = rf_read(d_rs, regs[d_rs], mw_we, mw_dst, wb_data);
  assign d_b = rf_read(d_rt, regs[d_rt], mw_we, mw_dst, wb_data);

  logic [XLEN-1:0] ie_a, ie_b, ie_imm;
  logic [4:0]      ie_rt, ie_rd;
  logic            ie_we, ie_ld, ie_st, ie_rr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_a <= '0; ie_b <= '0; ie_imm <= '0; ie_rt <= '0; ie_rd <= '0;
      ie_we <= 1'b0; ie_ld <= 1'b0; ie_st <= 1'b0; ie_rr <= 1'b0;
    end else begin
      ie_a   <= d_a;
      ie_b   <= d_b;
      ie_imm <= d_imm;
      ie_rt  <= d_rt;
      ie_rd  <= d_rd;
      ie_we  <= d_rr | d_ld;
      ie_ld  <= d_ld;
      ie_st  <= d_st;
      ie_rr  <= d_rr;
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] alu_y, alu_b;
  logic [5:0]      ex_fn;
  logic [4:0]      ex_sh, ex_dst;

  assign ex_fn  = ie_imm[5:0];
  assign ex_sh  = ie_imm[10:6];
  assign alu_b  = ie_rr ? ie_b : ie_imm;
  assign ex_dst = ie_rr ? ie_rd : ie_rt;

  always_comb begin
    if (!ie_rr) alu_y = ie_a + alu_b;
    else begin
      case (ex_fn)
        FN_ADD:  alu_y = ie_a + alu_b;
        FN_SUB:  alu_y = ie_a - alu_b;
        FN_AND:  alu_y = ie_a & alu_b;
        FN_OR:   alu_y = ie_a | alu_b;
        FN_SLL:  alu_y = alu_b << ex_sh;
        default: alu_y = '0;
      endcase
    end
  end

  logic [XLEN-1:0] em_alu;
  logic [4:0]      em_dst;
  logic            em_we, em_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      em_alu <= '0; em_dst <= '0; em_we <= 1'b0; em_ld <= 1'b0;
    end else begin
      em_alu <= alu_y;
      em_dst <= ex_dst;
      em_we  <= ie_we;
      em_ld  <= ie_ld;
    end
  end

  // ---------------- data memory (own input registers) ----------------
  logic [XLEN-1:0] dmem [DMEM_DEPTH];
  logic [DAW-1:0]  dm_addr_q;
  logic [XLEN-1:0] dm_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_DEPTH; i++)
        dmem[i] <= (i == SEED_A_IDX) ? XLEN'(SEED_A) :
                   (i == SEED_B_IDX) ? XLEN'(SEED_B) : '0;
      dm_addr_q <= '0;
    end else begin
      dm_addr_q <= alu_y[DAW-1:0];
      if (ie_st) dmem[alu_y[DAW-1:0]] <= ie_b;
    end
  end
  assign dm_rdata = dmem[dm_addr_q];

  // ---------------- writeback ----------------
  logic [XLEN-1:0] mw_alu, mw_mem;
  logic            mw_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      mw_alu <= '0; mw_mem <= '0; mw_dst <= '0; mw_we <= 1'b0; mw_ld <= 1'b0;
    end else begin
      mw_alu <= em_alu;
      mw_mem <= dm_rdata;
      mw_dst <= em_dst;
      mw_we  <= em_we;
      mw_ld  <= em_ld;
    end
  end
  assign wb_data = mw_ld ? mw_mem : mw_alu;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= XLEN'(i);
    end else if (mw_we && (mw_dst != 5'd0)) begin
      regs[mw_dst] <= wb_data;
    end
  end

  assign dbg_pc      = pc_q;
  assign dbg_instr   = ifid_q;
  assign dbg_alu     = alu_y;
  assign dbg_wb_data = wb_data;
  assign dbg_wb_reg  = mw_dst;
  assign dbg_wb_en   = mw_we;
  assign dbg_mem_we  = ie_st;

  // ---------------- assertions ----------------
  AST_FETCH_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ifid_q == 32'd0 && !mw_we && !ie_st)); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc_q == $past(pc_q) + XLEN'(4))); // R2
  AST_ALU_TO_WB: assert property (@(posedge clk) disable iff (rst)
    (ie_we && !ie_ld) |=> ##1 (mw_we && wb_data == $past(alu_y, 2))); // R3
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    ie_st |=> ##1 !mw_we); // R6
  AST_ZERO_KEPT: assert property (@(posedge clk) disable iff (rst)
    (mw_we && mw_dst == 5'd0) |=> (regs[0] == '0)); // R8
endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
  localparam int NCAP = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc, dbg_instr, dbg_alu, dbg_wb_data;
  logic [4:0]  dbg_wb_reg;
  logic        dbg_wb_en, dbg_mem_we;

  pipe5_core u_pipe5_core (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_instr(dbg_instr),
    .dbg_alu(dbg_alu), .dbg_wb_data(dbg_wb_data), .dbg_wb_reg(dbg_wb_reg),
    .dbg_wb_en(dbg_wb_en), .dbg_mem_we(dbg_mem_we)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] c_pc [NCAP+1], c_ins [NCAP+1], c_alu [NCAP+1], c_wd [NCAP+1];
  logic [4:0]  c_wr [NCAP+1];
  logic        c_we [NCAP+1], c_st [NCAP+1];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int s, t, d, f);
    return (32'(s) << 21) | (32'(t) << 16) | (32'(d) << 11) | 32'(f);
  endfunction
  function automatic logic [31:0] enc_i(input int o, s, t, input logic [15:0] im);
    return (32'(o) << 26) | (32'(s) << 21) | (32'(t) << 16) | {16'd0, im};
  endfunction
  function automatic logic [31:0] prog(input int i);
    case (i)
      0:  return enc_i(8'h23, 1, 10, 16'd20);
      1:  return enc_r(2, 3, 11, 8'h22);
      2:  return enc_r(4, 5, 12, 8'h24);
      3:  return enc_r(6, 7, 13, 8'h25);
      4:  return enc_r(8, 9, 14, 8'h20);
      5:  return enc_i(8'h23, 1, 15, 16'd24);
      6:  return enc_r(8, 9, 0, 8'h20);
      7:  return enc_r(14, 11, 20, 8'h20);
      8:  return enc_i(8'h2B, 2, 10, 16'd3);
      9:  return enc_r(0, 0, 17, 8'h20);
      10: return enc_i(8'h23, 22, 21, 16'hFFFF);
      11: return enc_i(8'h23, 0, 16, 16'd5);
      12: return enc_r(15, 10, 18, 8'h25);
      13: return enc_r(14, 13, 19, 8'h22);
      default: return 32'd0;
    endcase
  endfunction

  task automatic t_reset;
    chk("R1", "pc",    dbg_pc, 32'd0);
    chk("R1", "instr", dbg_instr, 32'd0);
    chk("R1", "wb_en", {31'd0, dbg_wb_en}, 32'd0);
    chk("R1", "st",    {31'd0, dbg_mem_we}, 32'd0);
  endtask

  task automatic t_fetch;
    for (int k = 1; k <= NCAP; k++) begin
      chk("R2", $sformatf("pc after edge %0d", k), c_pc[k], 32'(4 * k));
      chk("R2", $sformatf("instr after edge %0d", k), c_ins[k], prog(k - 1));
    end
  endtask

  task automatic t_alu;
    chk("R5",  "lw addr ALU",  c_alu[2],  32'd21);
    chk("R4",  "sub ALU",      c_alu[3],  32'hFFFFFFFF);
    chk("R4",  "and ALU",      c_alu[4],  32'd4);
    chk("R4",  "or ALU",       c_alu[5],  32'd7);
    chk("R4",  "add ALU",      c_alu[6],  32'd17);
    chk("R11", "neg offset",   c_alu[12], 32'd21);
    chk("R4",  "nop shift",    c_alu[18], 32'd0);
  endtask

  task automatic t_writeback;
    chk("R3",  "first wb_en",   {31'd0, c_we[4]}, 32'd1);
    chk("R5",  "lw data",       c_wd[4], 32'hAAAA5555);
    chk("R9",  "lw dest rt",    32'(c_wr[4]), 32'd10);
    chk("R12", "sub from reset regs", c_wd[5], 32'hFFFFFFFF);
    chk("R9",  "sub dest rd",   32'(c_wr[5]), 32'd11);
    chk("R3",  "and wb",        c_wd[6], 32'd4);
    chk("R3",  "or wb",         c_wd[7], 32'd7);
    chk("R3",  "add wb",        c_wd[8], 32'd17);
    chk("R9",  "add dest",      32'(c_wr[8]), 32'd14);
    chk("R7",  "word 25",       c_wd[9], 32'h5555AAAA);
    chk("R11", "neg offset lw", c_wd[14], 32'hAAAA5555);
    chk("R4",  "or of loads",   c_wd[16], 32'hFFFFFFFF);
    chk("R4",  "sub of results",c_wd[17], 32'd10);
  endtask

  task automatic t_store;
    chk("R6", "strobe before", {31'd0, c_st[9]},  32'd0);
    chk("R6", "strobe on sw",  {31'd0, c_st[10]}, 32'd1);
    chk("R6", "alu of sw",     c_alu[10], 32'd5);
    chk("R6", "no wb for sw",  {31'd0, c_we[12]}, 32'd0);
    chk("R6", "load back",     c_wd[15], 32'hAAAA5555);
    chk("R7", "word 5 was zero, now stored", 32'(c_wr[15]), 32'd16);
  endtask

  task automatic t_zero;
    chk("R8", "write to r0 shown", 32'(c_wr[10]), 32'd0);
    chk("R8", "r0 write enable",   {31'd0, c_we[10]}, 32'd1);
    chk("R8", "r0 reads zero",     c_wd[13], 32'd0);
    chk("R8", "dest r17",          32'(c_wr[13]), 32'd17);
  endtask

  task automatic t_bypass;
    chk("R10", "same-cycle read",  c_wd[11], 32'd16);
    chk("R10", "dest r20",         32'(c_wr[11]), 32'd20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst = 1'b0;
    for (int k = 1; k <= NCAP; k++) begin
      @(posedge clk);
      @(negedge clk);
      c_pc[k] = dbg_pc; c_ins[k] = dbg_instr; c_alu[k] = dbg_alu;
      c_wd[k] = dbg_wb_data; c_wr[k] = dbg_wb_reg;
      c_we[k] = dbg_wb_en; c_st[k] = dbg_mem_we;
    end
    t_fetch;
    t_alu;
    t_writeback;
    t_store;
    t_zero;
    t_bypass;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule